// File: doc/BRIEF.md
# Interrupt Source Controller

This block holds the per-source state for a bank of interrupt inputs and turns their activity into presentation requests for a single downstream presentation unit. Each source is fixed at build time as either edge-style (message-signalled, where every cycle with the input high is one event) or level-style (the input is a line that stays high while the device wants service). Every source carries a target server number and an 8-bit priority. A priority of 0xFF masks the source.

A request carries the global source number, which is the local index plus a base offset, together with the priority and server of that source. At most one request is outstanding. The presentation unit answers each request with accept or reject on `rsp_valid`/`rsp_accept`. It can also reject an earlier accepted source by number, signal end-of-interrupt by number, or ask for a resend. A resend makes the block offer again every source that still needs service, lowest index first.

Top module: `irq_src_layer`

## Requirements
- R1: After reset no request is presented, every priority is 0xFF (masked) and every status flag is clear. Each source keeps its build-time type (parameter `LSI_MAP`, bit i set = level-style).
- R2: A high input on an unmasked edge-style source raises a request with `req_num` = index + `OFFSET`, and with that source's priority and server.
- R3: A high input on a masked edge-style source records masked-pending and raises nothing. A later configuration write with a priority other than 0xFF clears masked-pending and raises the request.
- R4: A level-style source raises one request when its input changes and it is unmasked, high and not already sent, and it then marks itself sent. A steady high level raises nothing further while sent.
- R5: A reject answer marks an edge-style source rejected, and a resend then offers it again. For a level-style source a reject answer clears sent, and a resend then offers it again if it is still high.
- R6: On a resend, every rejected edge-style source has its rejected mark cleared and is re-offered if unmasked. Every level-style source runs the check of R4. Pending offers go out in ascending index order, and each one waits for its answer.
- R7: End-of-interrupt for a number inside [`OFFSET`, `OFFSET`+N) clears sent on a level-style source. It does not touch an edge-style source. Numbers outside that range are ignored.
- R8: A reject strobe by number has the same effect as a reject answer for that source. Numbers outside the source range are ignored.
- R9: A configuration write of priority 0xFF to a source whose request is waiting and not yet issued withdraws that request. An edge-style source becomes masked-pending and a level-style source clears sent. No request ever carries priority 0xFF.
- R10: While a request waits for its answer, its number, priority and server stay unchanged. After an answer, `req_valid` is low for at least one cycle.
- R11: A configuration write that unmasks a level-style source whose input is high and not sent raises a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | NSRC | Source inputs (edge: high = event, level: line) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IW | Local index written |
| cfg_server | input | SRV_W | Server number written |
| cfg_prio | input | 8 | Priority written (0xFF = masked) |
| rsp_valid | input | 1 | Answer to the outstanding request |
| rsp_accept | input | 1 | 1 = accepted, 0 = rejected |
| rej_valid | input | 1 | Reject strobe by number |
| rej_num | input | NUM_W | Global number rejected |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_num | input | NUM_W | Global number completed |
| resend | input | 1 | Resend request strobe |
| req_valid | output | 1 | Request outstanding |
| req_num | output | NUM_W | Global source number |
| req_prio | output | 8 | Priority of the request |
| req_server | output | SRV_W | Target server |

## Verification
The assertions check on every cycle that an outstanding request holds its fields until answered and idles for a cycle after the answer. They also check that no request ever shows the masking priority and that request numbers stay inside the source range. The bench scenarios are the only place to see the history-dependent parts: masked-pending release on a write, the rejected and sent flags across resend, and an end-of-interrupt that has no effect on edge-style sources. The same applies to ignored out-of-range numbers, the ascending order of re-offers, and the withdrawal of a queued request by a masking write.

// File: rtl/irq_src_layer.sv
module irq_src_layer #(
  parameter int NSRC = 8,
  parameter int NUM_W = 8,
  parameter int OFFSET = 16,
  parameter int SRV_W = 4,
  parameter logic [NSRC-1:0] LSI_MAP = 8'hF0,
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_in,
  input  logic             cfg_we,
  input  logic [IW-1:0]    cfg_idx,
  input  logic [SRV_W-1:0] cfg_server,
  input  logic [7:0]       cfg_prio,
  input  logic             rsp_valid,
  input  logic             rsp_accept,
  input  logic             rej_valid,
  input  logic [NUM_W-1:0] rej_num,
  input  logic             eoi_valid,
  input  logic [NUM_W-1:0] eoi_num,
  input  logic             resend,
  output logic             req_valid,
  output logic [NUM_W-1:0] req_num,
  output logic [7:0]       req_prio,
  output logic [SRV_W-1:0] req_server
);
  localparam logic [NUM_W-1:0] BASE = NUM_W'(OFFSET);
  localparam logic [NUM_W-1:0] LAST = NUM_W'(OFFSET + NSRC);

  logic [7:0]       prio_q [NSRC];
  logic [7:0]       prio_n [NSRC];
  logic [SRV_W-1:0] srv_q  [NSRC];
  logic [SRV_W-1:0] srv_n  [NSRC];
  logic [NSRC-1:0]  sent_q, sent_n, rej_q, rej_n, mp_q, mp_n, lvl_q, lvl_n, need_q, need_n;
  logic             busy_q;
  logic [IW-1:0]    cur_q, pick;
  logic [7:0]       rq_prio;
  logic [SRV_W-1:0] rq_srv;

  wire issue = !busy_q && |need_q;
  wire ans   = busy_q && rsp_valid;
  wire [NUM_W-1:0] rej_loc = rej_num - BASE;
  wire [NUM_W-1:0] eoi_loc = eoi_num - BASE;
  wire rej_hit = rej_valid && rej_num >= BASE && rej_num < LAST;
  wire eoi_hit = eoi_valid && eoi_num >= BASE && eoi_num < LAST;

  assign req_valid  = busy_q;
  assign req_num    = NUM_W'(cur_q) + BASE;
  assign req_prio   = rq_prio;
  assign req_server = rq_srv;

  always_comb begin
    pick = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (need_q[i]) pick = IW'(i);
  end

  always_comb begin
    sent_n = sent_q; rej_n = rej_q; mp_n = mp_q; lvl_n = lvl_q; need_n = need_q;
    for (int i = 0; i < NSRC; i++) begin
      logic chk;
      chk = 1'b0;
      prio_n[i] = prio_q[i];
      srv_n[i]  = srv_q[i];
      if ((ans && !rsp_accept && cur_q == IW'(i)) || (rej_hit && rej_loc == NUM_W'(i))) begin
        if (LSI_MAP[i]) sent_n[i] = 1'b0;
        else            rej_n[i]  = 1'b1;
      end
      if (eoi_hit && eoi_loc == NUM_W'(i) && LSI_MAP[i]) sent_n[i] = 1'b0;
      if (issue && pick == IW'(i)) need_n[i] = 1'b0;
      if (cfg_we && cfg_idx == IW'(i)) begin
        prio_n[i] = cfg_prio;
        srv_n[i]  = cfg_server;
        if (cfg_prio == 8'hFF && need_n[i]) begin
          need_n[i] = 1'b0;
          if (LSI_MAP[i]) sent_n[i] = 1'b0;
          else            mp_n[i]   = 1'b1;
        end
        if (LSI_MAP[i]) chk = 1'b1;
        else if (mp_n[i] && cfg_prio != 8'hFF) begin
          mp_n[i]   = 1'b0;
          need_n[i] = 1'b1;
        end
      end
      if (LSI_MAP[i]) begin
        lvl_n[i] = src_in[i];
        if (src_in[i] != lvl_q[i]) chk = 1'b1;
      end else if (src_in[i]) begin
        if (prio_n[i] == 8'hFF) mp_n[i]   = 1'b1;
        else                    need_n[i] = 1'b1;
      end
      if (resend) begin
        if (LSI_MAP[i]) chk = 1'b1;
        else if (rej_n[i]) begin
          rej_n[i] = 1'b0;
          if (prio_n[i] != 8'hFF) need_n[i] = 1'b1;
        end
      end
      if (LSI_MAP[i] && chk && prio_n[i] != 8'hFF && lvl_n[i] && !sent_n[i]) begin
        sent_n[i] = 1'b1;
        need_n[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) begin
        prio_q[i] <= 8'hFF;
        srv_q[i]  <= '0;
      end
      sent_q <= '0; rej_q <= '0; mp_q <= '0; lvl_q <= '0; need_q <= '0;
      busy_q <= 1'b0; cur_q <= '0; rq_prio <= 8'hFF; rq_srv <= '0;
    end else begin
      prio_q <= prio_n; srv_q <= srv_n;
      sent_q <= sent_n; rej_q <= rej_n; mp_q <= mp_n; lvl_q <= lvl_n; need_q <= need_n;
      if (issue) begin
        busy_q  <= 1'b1;
        cur_q   <= pick;
        rq_prio <= prio_q[pick];
        rq_srv  <= srv_q[pick];
      end else if (ans) begin
        busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_src_layer_chk.sv
module irq_src_layer_chk #(
  parameter int NSRC = 8,
  parameter int NUM_W = 8,
  parameter int OFFSET = 16,
  parameter int SRV_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [NUM_W-1:0] req_num,
  input logic [7:0]       req_prio,
  input logic [SRV_W-1:0] req_server,
  input logic             rsp_valid
);
  localparam logic [NUM_W-1:0] BASE = NUM_W'(OFFSET);
  localparam logic [NUM_W-1:0] LAST = NUM_W'(OFFSET + NSRC);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !rsp_valid |=> req_valid && $stable(req_num) && $stable(req_prio) && $stable(req_server)); // R10
  AST_GAP_AFTER_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && rsp_valid |=> !req_valid); // R10
  AST_NO_MASKED_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_prio != 8'hFF); // R9
  AST_NUM_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_num >= BASE && req_num < LAST)); // R2
endmodule

bind irq_src_layer irq_src_layer_chk #(.NSRC(NSRC), .NUM_W(NUM_W), .OFFSET(OFFSET), .SRV_W(SRV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_num(req_num),
  .req_prio(req_prio), .req_server(req_server), .rsp_valid(rsp_valid)
);

// File: tb/sim_irq_src_layer.sv
`timescale 1ns/1ps
module sim_irq_src_layer;
  logic       clk = 0, rst_n = 0;
  logic [7:0] src_in = '0;
  logic       cfg_we = 0;
  logic [2:0] cfg_idx = '0;
  logic [3:0] cfg_server = '0;
  logic [7:0] cfg_prio = '0;
  logic       rsp_valid = 0, rsp_accept = 0;
  logic       rej_valid = 0, eoi_valid = 0, resend = 0;
  logic [7:0] rej_num = '0, eoi_num = '0;
  logic       req_valid;
  logic [7:0] req_num, req_prio;
  logic [3:0] req_server;

  int tests = 0, fails = 0;
  logic [19:0] q[$];
  bit acc = 1, hold = 0, seen = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  irq_src_layer u0 (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_server(cfg_server), .cfg_prio(cfg_prio), .rsp_valid(rsp_valid),
    .rsp_accept(rsp_accept), .rej_valid(rej_valid), .rej_num(rej_num),
    .eoi_valid(eoi_valid), .eoi_num(eoi_num), .resend(resend),
    .req_valid(req_valid), .req_num(req_num), .req_prio(req_prio), .req_server(req_server)
  );

  always @(negedge clk) if (rst_n) begin
    if (rsp_valid) begin
      rsp_valid = 0;
      seen = 0;
    end else if (req_valid && !seen) begin
      seen = 1;
      tests++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL %s unexpected request got %h expected none", tag, {req_num, req_prio, req_server});
      end else begin
        logic [19:0] e;
        e = q.pop_front();
        if ({req_num, req_prio, req_server} !== e) begin
          fails++;
          $display("FAIL %s request got %h expected %h", tag, {req_num, req_prio, req_server}, e);
        end
      end
      if (!hold) begin rsp_valid = 1; rsp_accept = acc; end
    end else if (seen && !hold) begin
      rsp_valid = 1; rsp_accept = acc;
    end
  end

  task automatic expect_req(input logic [7:0] n, input logic [7:0] p, input logic [3:0] s);
    q.push_back({n, p, s});
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
    tests++;
    if (q.size() != 0 || req_valid) begin
      fails++;
      $display("FAIL %s pending expected requests got %0d expected 0", tag, q.size());
      q.delete();
    end
  endtask

  task automatic cfg(input int idx, input logic [7:0] p, input logic [3:0] s);
    @(negedge clk); cfg_we = 1; cfg_idx = 3'(idx); cfg_prio = p; cfg_server = s;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic pulse(input logic [7:0] m);
    @(negedge clk); src_in = src_in | m;
    @(negedge clk); src_in = src_in & ~m;
  endtask

  task automatic level(input int i, input logic v);
    @(negedge clk); src_in[i] = v;
  endtask

  task automatic do_resend();
    @(negedge clk); resend = 1;
    @(negedge clk); resend = 0;
  endtask

  task automatic do_rej(input logic [7:0] n);
    @(negedge clk); rej_valid = 1; rej_num = n;
    @(negedge clk); rej_valid = 0;
  endtask

  task automatic do_eoi(input logic [7:0] n);
    @(negedge clk); eoi_valid = 1; eoi_num = n;
    @(negedge clk); eoi_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired got running expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    tests++;
    if (req_valid !== 1'b0) begin fails++; $display("FAIL R1 req_valid got %b expected 0", req_valid); end
    tag = "R1"; pulse(8'h01); settle();

    tag = "R3"; expect_req(8'd16, 8'd5, 4'd2); cfg(0, 8'd5, 4'd2); settle();

    tag = "R2"; cfg(1, 8'd3, 4'd1); expect_req(8'd17, 8'd3, 4'd1); pulse(8'h02); settle();

    tag = "R4"; cfg(4, 8'd7, 4'd5); settle();
    expect_req(8'd20, 8'd7, 4'd5); level(4, 1); settle();
    do_resend(); settle();
    tag = "R7"; do_eoi(8'd20); settle();
    expect_req(8'd20, 8'd7, 4'd5); do_resend(); settle();
    level(4, 0); do_eoi(8'd20); settle();

    tag = "R5"; acc = 0; expect_req(8'd17, 8'd3, 4'd1); pulse(8'h02); settle();
    acc = 1; expect_req(8'd17, 8'd3, 4'd1); do_resend(); settle();
    do_resend(); settle();
    cfg(5, 8'd9, 4'd6); acc = 0; expect_req(8'd21, 8'd9, 4'd6); level(5, 1); settle();
    acc = 1; expect_req(8'd21, 8'd9, 4'd6); do_resend(); settle();
    do_eoi(8'd21); level(5, 0); settle();

    tag = "R6"; cfg(2, 8'd8, 4'd3); acc = 0;
    expect_req(8'd16, 8'd5, 4'd2); expect_req(8'd18, 8'd8, 4'd3); pulse(8'h05); settle();
    acc = 1; expect_req(8'd16, 8'd5, 4'd2); expect_req(8'd18, 8'd8, 4'd3); do_resend(); settle();

    tag = "R8"; cfg(6, 8'd4, 4'd7); expect_req(8'd22, 8'd4, 4'd7); level(6, 1); settle();
    do_rej(8'd22); expect_req(8'd22, 8'd4, 4'd7); do_resend(); settle();
    do_rej(8'd40); do_rej(8'd5); do_resend(); settle();
    tag = "R7"; do_eoi(8'd3); do_resend(); settle();
    do_eoi(8'd22); expect_req(8'd22, 8'd4, 4'd7); do_resend(); settle();
    acc = 0; expect_req(8'd16, 8'd5, 4'd2); pulse(8'h01); settle();
    acc = 1; do_eoi(8'd16); expect_req(8'd16, 8'd5, 4'd2); do_resend(); settle();

    tag = "R9"; hold = 1; expect_req(8'd17, 8'd3, 4'd1); pulse(8'h02);
    repeat (4) @(negedge clk);
    tests++;
    if (!(req_valid && req_num == 8'd17)) begin
      fails++; $display("FAIL R10 held request got %b/%0d expected 1/17", req_valid, req_num);
    end
    pulse(8'h01); cfg(0, 8'hFF, 4'd2); hold = 0; settle();
    tag = "R3"; expect_req(8'd16, 8'd6, 4'd2); cfg(0, 8'd6, 4'd2); settle();

    tag = "R11"; level(7, 1); settle();
    expect_req(8'd23, 8'd2, 4'd0); cfg(7, 8'd2, 4'd0); settle();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule